// File: doc/BRIEF.md
# Block-Boundary Split Memory Access Unit

This unit sits between a core's load/store path and a data memory port. It accepts one access at a time (start address, byte count, write data, operation kind and per-half fault flags) and turns it into one or two memory transactions. When the bytes of the access lie in two different cache blocks, the access is cut at the block boundary into a low fragment and a high fragment. The low fragment is always offered first, and the core sees a single merged response once every fragment has come back.

The memory side uses a valid/ready offer. If an offer is refused, the unit withdraws it and waits for a retry pulse before offering the same fragment again. A response flagged as negatively acknowledged is not counted: its fragment is offered again. Atomic operations (locked reads, locked writes, swaps) are never cut in two. Faulting accesses and accesses flagged as needing no memory access finish at once, with no memory traffic.

Top module: `split_mem_unit`

## Requirements
- R1: With E = addr + size − 1 and P = E rounded down to a multiple of BLOCK_BYTES, the access is cut into two fragments exactly when P > addr. Every memory offer lies wholly inside one block and has a non-zero size. Sizes run from 1 to MAX_BYTES.
- R2: The low fragment has tag 0, address addr and size P − addr. The high fragment has tag 1, address P and size equal to the rest. Write data bytes are low-aligned per fragment, so the high fragment carries request bytes starting at byte offset P − addr, and bytes beyond a fragment's size are zero. Tag 1 is never offered before tag 0 has been accepted.
- R3: For reads, rsp_rdata byte i equals the byte the memory returned for address addr + i, for i < size. Every other byte is zero, and returned bytes beyond a fragment's size are discarded. For writes, rsp_rdata is zero.
- R4: A locked request (req_locked), or a write with req_swap, that would be cut in two gives rsp_valid with rsp_err = 1 in the cycle after acceptance, and makes no memory offer. req_swap has no effect on reads.
- R5: Exactly one rsp_valid pulse follows each accepted request. For memory traffic, it comes only after a non-nacked response has arrived for every fragment.
- R6: In the cycle after an offer is refused (mem_req_valid high, mem_req_ready low), mem_req_valid is low. It stays low until mem_retry has been seen. Then the same fragment is offered on the next cycle, and after it is accepted the remaining fragment is offered.
- R7: A response with mem_rsp_nack = 1 does not complete its fragment. That fragment is offered again, and a refused re-offer goes through the R6 retry path.
- R8: If the low-half fault, or the high-half fault of an access that is cut, is set, no memory offer is made and rsp_valid comes in the cycle after acceptance. rsp_fault = 1, and rsp_fault_hi = 0 when the low-half fault is set, otherwise 1. With req_prefetch set, both fault outputs are 0. The high-half fault flag is ignored when the access is not cut.
- R9: mem_req_cmd encodes: 0 read, 1 locked read, 2 write, 3 locked write (store-conditional), 4 swap. A locked write takes precedence over a swap.
- R10: A request with req_no_access (and no error or fault) completes in the cycle after acceptance, with zero data and no memory offer.
- R11: After reset, req_ready = 1 and rsp_valid = mem_req_valid = 0. req_ready is low from the cycle after acceptance until the rsp_valid cycle has passed, and rsp_valid lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core offers an access |
| req_ready | output | 1 | Unit idle and able to take an access |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | SZ_W | Byte count, 1..MAX_BYTES |
| req_wdata | input | DATA_W | Write data, byte 0 at the start address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_locked | input | 1 | Locked read / store-conditional |
| req_swap | input | 1 | Swap (writes only) |
| req_prefetch | input | 1 | Prefetch: faults suppressed |
| req_no_access | input | 1 | Complete without memory traffic |
| req_fault_lo | input | 1 | Fault on the low fragment |
| req_fault_hi | input | 1 | Fault on the high fragment |
| rsp_valid | output | 1 | Merged response, one cycle |
| rsp_rdata | output | DATA_W | Merged read data |
| rsp_err | output | 1 | Atomic access would have been cut |
| rsp_fault | output | 1 | Access faulted |
| rsp_fault_hi | output | 1 | Fault came from the high fragment |
| mem_req_valid | output | 1 | Fragment offered to memory |
| mem_req_ready | input | 1 | Memory accepts the offer |
| mem_req_addr | output | ADDR_W | Fragment address |
| mem_req_size | output | SZ_W | Fragment byte count |
| mem_req_cmd | output | 3 | Command code (R9) |
| mem_req_wdata | output | DATA_W | Fragment write data, low-aligned |
| mem_req_tag | output | 1 | 0 low fragment, 1 high fragment |
| mem_retry | input | 1 | Memory can now take a refused offer |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_nack | input | 1 | Response is a negative acknowledge |
| mem_rsp_tag | input | 1 | Fragment the response belongs to |
| mem_rsp_rdata | input | DATA_W | Response data, low-aligned |

## Verification
The bench drives accesses that end exactly on a block edge, that cross it with one byte below the boundary, and that cross it with one byte above it. It checks fragment addresses, sizes and data shifts against its own split arithmetic, so an off-by-one in the split point shows up as a wrong fragment size or a stray third byte. The memory model pads responses with filler bytes, which a merge that ignores fragment sizes would leak into the read data. Refusal and nack modes are run alone and together, including a nack that arrives while the other fragment is still held for retry. A design that re-offers too early, skips the held fragment, or counts a nack as a completion shows up as an unexpected offer or as an early or missing response. Atomic operations that cross a boundary, faults in either half or both halves, prefetch suppression and no-access requests are each checked for their single-cycle completion and for the absence of any memory offer.

// File: rtl/split_pkg.sv
package split_pkg;

  typedef enum logic [2:0] {
    CMD_READ       = 3'd0,
    CMD_LOAD_LOCK  = 3'd1,
    CMD_WRITE      = 3'd2,
    CMD_STORE_COND = 3'd3,
    CMD_SWAP       = 3'd4
  } mem_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_RETRY,
    ST_WAIT,
    ST_DONE
  } ctrl_st_e;

  // locked form wins over swap for writes
  function automatic mem_cmd_e pick_cmd(input logic wr, input logic lk, input logic sw);
    if (!wr) return lk ? CMD_LOAD_LOCK : CMD_READ;
    if (lk) return CMD_STORE_COND;
    if (sw) return CMD_SWAP;
    return CMD_WRITE;
  endfunction

  function automatic logic is_atomic(input logic wr, input logic lk, input logic sw);
    return lk | (wr & sw);
  endfunction

endpackage

// File: rtl/split_planner.sv
module split_planner
  import split_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 8,
  parameter int SZ_W        = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SZ_W-1:0]   size,
  input  logic              wr,
  input  logic              lk,
  input  logic              sw,
  input  logic              pf,
  input  logic              noacc,
  input  logic              flt_lo,
  input  logic              flt_hi,
  output logic              crosses,
  output logic [SZ_W-1:0]   size0,
  output logic [SZ_W-1:0]   size1,
  output logic [ADDR_W-1:0] addr1,
  output mem_cmd_e          cmd,
  output logic              err_atomic,
  output logic              fault,
  output logic              fault_hi,
  output logic              bypass
);

  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLOCK_BYTES - 1);

  // start of the block that holds the last byte of the access
  function automatic logic [ADDR_W-1:0] split_point(input logic [ADDR_W-1:0] a,
                                                    input logic [SZ_W-1:0] s);
    return (a + ADDR_W'(s) - ADDR_W'(1)) & ~OFF_MASK;
  endfunction

  logic [ADDR_W-1:0] sp;
  logic              f_lo, f_hi;

  always_comb begin
    sp         = split_point(addr, size);
    crosses    = sp > addr;
    size0      = crosses ? SZ_W'(sp - addr) : size;
    size1      = size - size0;
    addr1      = sp;
    cmd        = pick_cmd(wr, lk, sw);
    err_atomic = crosses & is_atomic(wr, lk, sw);
    f_lo       = flt_lo;
    f_hi       = crosses & flt_hi;
    fault      = !err_atomic && !pf && (f_lo || f_hi);
    fault_hi   = !f_lo;
    bypass     = err_atomic | f_lo | f_hi | noacc;
  end

endmodule

// File: rtl/split_rd_merge.sv
module split_rd_merge #(
  parameter int MAX_BYTES = 8,
  parameter int SZ_W      = 4,
  localparam int DATA_W   = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              tag,
  input  logic [SZ_W-1:0]   size0,
  input  logic [SZ_W-1:0]   size1,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] shifted;
  logic [SZ_W:0]     lo, hi;
  logic [7:0]        rbuf [MAX_BYTES];

  function automatic logic in_window(input int idx, input logic [SZ_W:0] a, input logic [SZ_W:0] b);
    return (idx >= int'(a)) && (idx < int'(b));
  endfunction

  always_comb begin
    shifted = tag ? (din << {size0, 3'b000}) : din;
    lo      = tag ? {1'b0, size0} : '0;
    hi      = tag ? ({1'b0, size0} + {1'b0, size1}) : {1'b0, size0};
  end

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n || clear) rbuf[i] <= 8'h00;
      else if (load && in_window(i, lo, hi)) rbuf[i] <= shifted[8*i +: 8];
    end
    assign rdata[8*i +: 8] = rbuf[i];
  end

endmodule

// File: rtl/split_ctrl.sv
module split_ctrl
  import split_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [ADDR_W-1:0] in_addr0,
  input  logic [ADDR_W-1:0] in_addr1,
  input  logic [SZ_W-1:0]   in_size0,
  input  logic [SZ_W-1:0]   in_size1,
  input  logic [DATA_W-1:0] in_wdata,
  input  mem_cmd_e          in_cmd,
  input  logic              in_crosses,
  input  logic              in_err,
  input  logic              in_fault,
  input  logic              in_fault_hi,
  input  logic              in_bypass,
  input  logic              mem_req_ready,
  input  logic              mem_retry,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_nack,
  input  logic              mem_rsp_tag,
  output logic              idle,
  output logic              done,
  output logic              mem_req_valid,
  output logic              cur_tag,
  output logic [ADDR_W-1:0] lat_addr0,
  output logic [ADDR_W-1:0] lat_addr1,
  output logic [SZ_W-1:0]   lat_size0,
  output logic [SZ_W-1:0]   lat_size1,
  output logic [DATA_W-1:0] lat_wdata,
  output mem_cmd_e          lat_cmd,
  output logic              lat_err,
  output logic              lat_fault,
  output logic              lat_fault_hi,
  output logic              ev_good_rsp,
  output logic              is_read
);

  ctrl_st_e   state, state_n;
  logic [1:0] pend, pend_n;
  logic [1:0] outs, outs_n;
  logic       in_flight, ev_accept, ev_refuse, ev_nack;

  function automatic logic [1:0] tag_bit(input logic t);
    return t ? 2'b10 : 2'b01;
  endfunction

  always_comb begin
    idle          = state == ST_IDLE;
    done          = state == ST_DONE;
    mem_req_valid = state == ST_ISSUE;
    cur_tag       = ~pend[0];
    in_flight     = (state == ST_ISSUE) || (state == ST_RETRY) || (state == ST_WAIT);
    ev_accept     = mem_req_valid && mem_req_ready;
    ev_refuse     = mem_req_valid && !mem_req_ready;
    ev_good_rsp   = in_flight && mem_rsp_valid && !mem_rsp_nack;
    ev_nack       = in_flight && mem_rsp_valid && mem_rsp_nack;
    is_read       = (lat_cmd == CMD_READ) || (lat_cmd == CMD_LOAD_LOCK);
  end

  always_comb begin
    state_n = state;
    pend_n  = (pend & ~(ev_accept ? tag_bit(cur_tag) : 2'b00)) |
              (ev_nack ? tag_bit(mem_rsp_tag) : 2'b00);
    outs_n  = outs - 2'(ev_good_rsp);
    case (state)
      ST_IDLE: begin
        pend_n = '0;
        outs_n = '0;
        if (req_fire) begin
          if (in_bypass) state_n = ST_DONE;
          else begin
            pend_n  = in_crosses ? 2'b11 : 2'b01;
            outs_n  = in_crosses ? 2'd2 : 2'd1;
            state_n = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (ev_refuse) state_n = ST_RETRY;
        else if (outs_n == 2'd0) state_n = ST_DONE;
        else if (pend_n == 2'b00) state_n = ST_WAIT;
      end
      ST_RETRY: if (mem_retry) state_n = ST_ISSUE;
      ST_WAIT: begin
        if (outs_n == 2'd0) state_n = ST_DONE;
        else if (pend_n != 2'b00) state_n = ST_ISSUE;
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      pend         <= '0;
      outs         <= '0;
      lat_addr0    <= '0;
      lat_addr1    <= '0;
      lat_size0    <= '0;
      lat_size1    <= '0;
      lat_wdata    <= '0;
      lat_cmd      <= CMD_READ;
      lat_err      <= 1'b0;
      lat_fault    <= 1'b0;
      lat_fault_hi <= 1'b0;
    end else begin
      state <= state_n;
      pend  <= pend_n;
      outs  <= outs_n;
      if (req_fire) begin
        lat_addr0    <= in_addr0;
        lat_addr1    <= in_addr1;
        lat_size0    <= in_size0;
        lat_size1    <= in_size1;
        lat_wdata    <= in_wdata;
        lat_cmd      <= in_cmd;
        lat_err      <= in_err;
        lat_fault    <= in_fault;
        lat_fault_hi <= in_fault && in_fault_hi;
      end
    end
  end

  // R6: a refused offer is withdrawn on the next cycle
  assert_withdraw_on_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> !mem_req_valid);

  // R6: no offer while waiting for the retry pulse
  assert_hold_until_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RETRY && !mem_retry) |=> !mem_req_valid);

  // R5: the merged response only goes out with nothing outstanding
  assert_count_drained_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (outs == 2'd0 && pend == 2'b00));

  // R5: never more than two fragments tracked
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    outs != 2'd3);

  // R7: a nack never completes the access
  assert_nack_not_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && mem_rsp_valid && mem_rsp_nack) |=> !done);

  // R10: no-traffic requests finish in the next cycle
  assert_bypass_fast_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && in_bypass) |=> done);

endmodule

// File: rtl/split_mem_unit.sv
module split_mem_unit
  import split_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 8,
  parameter int MAX_BYTES   = 8,
  localparam int DATA_W     = 8 * MAX_BYTES,
  localparam int SZ_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_locked,
  input  logic              req_swap,
  input  logic              req_prefetch,
  input  logic              req_no_access,
  input  logic              req_fault_lo,
  input  logic              req_fault_hi,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_fault,
  output logic              rsp_fault_hi,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [SZ_W-1:0]   mem_req_size,
  output logic [2:0]        mem_req_cmd,
  output logic [DATA_W-1:0] mem_req_wdata,
  output logic              mem_req_tag,
  input  logic              mem_retry,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_nack,
  input  logic              mem_rsp_tag,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);

  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLOCK_BYTES - 1);

  function automatic logic [DATA_W-1:0] byte_mask(input logic [SZ_W-1:0] n);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < MAX_BYTES; b++) m[8*b +: 8] = (b < int'(n)) ? 8'hFF : 8'h00;
    return m;
  endfunction

  logic              req_fire;
  logic              p_crosses, p_err, p_fault, p_fault_hi, p_bypass;
  logic [SZ_W-1:0]   p_size0, p_size1;
  logic [ADDR_W-1:0] p_addr1;
  mem_cmd_e          p_cmd;

  logic              c_idle, c_done, c_tag, c_good, c_read;
  logic [ADDR_W-1:0] l_addr0, l_addr1;
  logic [SZ_W-1:0]   l_size0, l_size1;
  logic [DATA_W-1:0] l_wdata;
  mem_cmd_e          l_cmd;
  logic              l_err, l_fault, l_fault_hi;
  logic              lo_sent;

  assign req_fire = req_valid && req_ready;

  split_planner #(
    .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .SZ_W(SZ_W)
  ) u_plan (
    .addr(req_addr), .size(req_size), .wr(req_write), .lk(req_locked),
    .sw(req_swap), .pf(req_prefetch), .noacc(req_no_access),
    .flt_lo(req_fault_lo), .flt_hi(req_fault_hi),
    .crosses(p_crosses), .size0(p_size0), .size1(p_size1), .addr1(p_addr1),
    .cmd(p_cmd), .err_atomic(p_err), .fault(p_fault), .fault_hi(p_fault_hi),
    .bypass(p_bypass)
  );

  split_ctrl #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire),
    .in_addr0(req_addr), .in_addr1(p_addr1), .in_size0(p_size0), .in_size1(p_size1),
    .in_wdata(req_wdata), .in_cmd(p_cmd), .in_crosses(p_crosses), .in_err(p_err),
    .in_fault(p_fault), .in_fault_hi(p_fault_hi), .in_bypass(p_bypass),
    .mem_req_ready(mem_req_ready), .mem_retry(mem_retry),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_nack(mem_rsp_nack), .mem_rsp_tag(mem_rsp_tag),
    .idle(c_idle), .done(c_done), .mem_req_valid(mem_req_valid), .cur_tag(c_tag),
    .lat_addr0(l_addr0), .lat_addr1(l_addr1), .lat_size0(l_size0), .lat_size1(l_size1),
    .lat_wdata(l_wdata), .lat_cmd(l_cmd), .lat_err(l_err), .lat_fault(l_fault),
    .lat_fault_hi(l_fault_hi), .ev_good_rsp(c_good), .is_read(c_read)
  );

  split_rd_merge #(
    .MAX_BYTES(MAX_BYTES), .SZ_W(SZ_W)
  ) u_merge (
    .clk(clk), .rst_n(rst_n), .clear(req_fire), .load(c_good && c_read),
    .tag(mem_rsp_tag), .size0(l_size0), .size1(l_size1), .din(mem_rsp_rdata),
    .rdata(rsp_rdata)
  );

  always_comb begin
    req_ready     = c_idle;
    rsp_valid     = c_done;
    rsp_err       = l_err;
    rsp_fault     = l_fault;
    rsp_fault_hi  = l_fault_hi;
    mem_req_tag   = c_tag;
    mem_req_cmd   = l_cmd;
    mem_req_addr  = c_tag ? l_addr1 : l_addr0;
    mem_req_size  = c_tag ? l_size1 : l_size0;
    mem_req_wdata = c_tag ? ((l_wdata >> {l_size0, 3'b000}) & byte_mask(l_size1))
                          : (l_wdata & byte_mask(l_size0));
  end

  // low fragment accepted at least once for the current access
  always_ff @(posedge clk) begin
    if (!rst_n || req_fire) lo_sent <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_tag) lo_sent <= 1'b1;
  end

  // R1: each offer stays inside one block and is non-empty
  assert_within_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_size != '0 &&
      ((mem_req_addr & ~OFF_MASK) ==
       ((mem_req_addr + ADDR_W'(mem_req_size) - ADDR_W'(1)) & ~OFF_MASK))));

  // R2: the high fragment never goes before the low one
  assert_low_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_tag) |-> lo_sent);

  // R4: atomic commands only ever go out whole
  assert_atomic_whole_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && (mem_req_cmd == CMD_LOAD_LOCK || mem_req_cmd == CMD_STORE_COND ||
                       mem_req_cmd == CMD_SWAP)) |-> (!mem_req_tag && l_size1 == '0));

  // R11: no new access is taken while a response is going out
  assert_busy_on_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

// File: tb/split_mem_unit_bench.sv
module split_mem_unit_bench;

  localparam int ADDR_W = 16;
  localparam int BLOCK  = 8;
  localparam int MAXB   = 8;
  localparam int SZ_W   = 4;
  localparam int DW     = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid = 0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SZ_W-1:0]   req_size = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic req_write = 0, req_locked = 0, req_swap = 0, req_prefetch = 0;
  logic req_no_access = 0, req_fault_lo = 0, req_fault_hi = 0;
  logic              rsp_valid, rsp_err, rsp_fault, rsp_fault_hi;
  logic [DW-1:0]     rsp_rdata;
  logic              mem_req_valid, mem_req_tag;
  logic              mem_req_ready = 0, mem_retry = 0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [SZ_W-1:0]   mem_req_size;
  logic [2:0]        mem_req_cmd;
  logic [DW-1:0]     mem_req_wdata;
  logic              mem_rsp_valid = 0, mem_rsp_nack = 0, mem_rsp_tag = 0;
  logic [DW-1:0]     mem_rsp_rdata = '0;

  split_mem_unit #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK), .MAX_BYTES(MAXB)) u_split_mem_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_write(req_write), .req_locked(req_locked), .req_swap(req_swap),
    .req_prefetch(req_prefetch), .req_no_access(req_no_access),
    .req_fault_lo(req_fault_lo), .req_fault_hi(req_fault_hi),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rsp_fault(rsp_fault), .rsp_fault_hi(rsp_fault_hi),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size), .mem_req_cmd(mem_req_cmd),
    .mem_req_wdata(mem_req_wdata), .mem_req_tag(mem_req_tag), .mem_retry(mem_retry),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_nack(mem_rsp_nack),
    .mem_rsp_tag(mem_rsp_tag), .mem_rsp_rdata(mem_rsp_rdata)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    int                size;
    logic [2:0]        cmd;
    logic              tag;
    logic [DW-1:0]     wdata;
    bit                nacked;
  } frag_t;

  typedef struct {
    logic [DW-1:0] rdata;
    logic          err, fault, fhi;
  } rsp_t;

  frag_t expq[$];
  frag_t accq[$];
  rsp_t  rspq[$];
  int    n_chk = 0, n_fail = 0;
  bit    refuse_mode = 0, nack_mode = 0;
  string cur_r = "";

  function automatic logic [7:0] mbyte(input logic [ADDR_W-1:0] a);
    return 8'(a * 13) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  // memory model: checks offers, refuses, nacks and answers
  initial begin
    int    retry_cnt;
    bit    head_refused, have_rsp;
    frag_t f, r;
    logic [DW-1:0] d;
    retry_cnt = 0;
    head_refused = 0;
    forever begin
      @(negedge clk);
      mem_req_ready = 0; mem_retry = 0; mem_rsp_valid = 0; mem_rsp_nack = 0;
      have_rsp = accq.size() > 0;
      if (have_rsp) r = accq.pop_front();
      if (retry_cnt > 0) begin
        if (mem_req_valid)
          chk(0, "R6", "offer while awaiting retry", 1, 0);
        retry_cnt--;
        if (retry_cnt == 0) mem_retry = 1;
      end else if (mem_req_valid) begin
        if (expq.size() == 0) begin
          chk(0, "R1 R4 R8 R10", "unexpected memory offer", {48'd0, mem_req_addr}, 0);
        end else begin
          f = expq[0];
          chk({mem_req_addr, mem_req_size, mem_req_cmd, mem_req_tag} ==
              {f.addr, SZ_W'(f.size), f.cmd, f.tag},
              "R1 R2 R9", {cur_r, " fragment addr/size/cmd/tag"},
              {40'd0, mem_req_addr, mem_req_size, mem_req_cmd, mem_req_tag},
              {40'd0, f.addr, SZ_W'(f.size), f.cmd, f.tag});
          chk(mem_req_wdata == f.wdata, "R2", {cur_r, " fragment wdata"}, mem_req_wdata, f.wdata);
          if (refuse_mode && !head_refused) begin
            head_refused = 1;
            retry_cnt = 2;
          end else begin
            mem_req_ready = 1;
            head_refused = 0;
            accq.push_back(expq.pop_front());
          end
        end
      end
      if (have_rsp) begin
        for (int j = 0; j < MAXB; j++)
          d[8*j +: 8] = (r.cmd <= 3'd1 && j < r.size) ? mbyte(r.addr + ADDR_W'(j)) : 8'hEE;
        mem_rsp_valid = 1;
        mem_rsp_tag = r.tag;
        mem_rsp_rdata = d;
        if (nack_mode && !r.nacked) begin
          mem_rsp_nack = 1;
          r.nacked = 1;
          expq.push_front(r);
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    rsp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (rspq.size() == 0) chk(0, "R5", "response with none expected", 1, 0);
        else begin
          e = rspq.pop_front();
          chk(rsp_rdata == e.rdata, "R3", {cur_r, " merged rdata"}, rsp_rdata, e.rdata);
          chk({rsp_err, rsp_fault, rsp_fault_hi} == {e.err, e.fault, e.fhi}, "R4 R8",
              {cur_r, " err/fault/fault_hi"}, {61'd0, rsp_err, rsp_fault, rsp_fault_hi},
              {61'd0, e.err, e.fault, e.fhi});
        end
      end
    end
  end

  // driver: computes expectations, pushes them, then drives the access
  task automatic send(input logic [ADDR_W-1:0] addr, input int size, input logic [DW-1:0] wd,
                      input bit wr, input bit lk, input bit sw, input bit pf, input bit na,
                      input bit f0, input bit f1, input string r);
    int   last, blk, s0;
    bit   cut, atomic, ff0, ff1, quick;
    rsp_t e;
    frag_t f;
    logic [2:0] cmd;
    cur_r = r;
    last  = int'(addr) + size - 1;
    blk   = last - (last % BLOCK);
    cut   = blk > int'(addr);
    s0    = cut ? blk - int'(addr) : size;
    atomic = lk || (wr && sw);
    ff0   = f0;
    ff1   = cut && f1;
    cmd   = !wr ? (lk ? 3'd1 : 3'd0) : (lk ? 3'd3 : (sw ? 3'd4 : 3'd2));
    e.rdata = '0; e.err = 0; e.fault = 0; e.fhi = 0;
    quick = 1;
    if (cut && atomic) e.err = 1;
    else if (ff0 || ff1) begin
      e.fault = !pf;
      e.fhi   = !pf && !ff0;
    end else if (!na) begin
      quick = 0;
      f.nacked = 0;
      f.cmd = cmd;
      f.addr = addr; f.size = s0; f.tag = 0; f.wdata = '0;
      for (int j = 0; j < s0; j++) f.wdata[8*j +: 8] = wd[8*j +: 8];
      expq.push_back(f);
      if (cut) begin
        f.addr = ADDR_W'(blk); f.size = size - s0; f.tag = 1; f.wdata = '0;
        for (int j = 0; j < size - s0; j++) f.wdata[8*j +: 8] = wd[8*(s0+j) +: 8];
        expq.push_back(f);
      end
      if (!wr)
        for (int j = 0; j < size; j++) e.rdata[8*j +: 8] = mbyte(addr + ADDR_W'(j));
    end
    rspq.push_back(e);
    while (!req_ready) @(negedge clk);
    req_addr = addr; req_size = SZ_W'(size); req_wdata = wd;
    req_write = wr; req_locked = lk; req_swap = sw; req_prefetch = pf;
    req_no_access = na; req_fault_lo = f0; req_fault_hi = f1;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R11", {r, " ready low after accept"}, {63'd0, req_ready}, 0);
    if (quick)
      chk(rsp_valid, "R10 R8 R4", {r, " one-cycle completion"}, {63'd0, rsp_valid}, 1);
    while (rspq.size() > 0 || expq.size() > 0 || accq.size() > 0) @(negedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R11 R5", {r, " idle after single response"},
        {62'd0, req_ready, rsp_valid}, 64'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", "run hung", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R11", "reset state",
        {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'd4);

    // R1 R3: whole-block read, last byte on block edge
    send(16'h0100, 8, '0, 0, 0, 0, 0, 0, 0, 0, "R1 aligned read");
    send(16'h0104, 4, '0, 0, 0, 0, 0, 0, 0, 0, "R1 ends on edge");
    // R2 R3: crossing reads
    send(16'h0106, 4, '0, 0, 0, 0, 0, 0, 0, 0, "R2 split read 2+2");
    send(16'h010F, 8, '0, 0, 0, 0, 0, 0, 0, 0, "R2 split read 1+7");
    send(16'h0119, 8, '0, 0, 0, 0, 0, 0, 0, 0, "R2 split read 7+1");
    // R2 R9: crossing write, write response data zero
    send(16'h021D, 5, 64'h1122334455667788, 1, 0, 0, 0, 0, 0, 0, "R2 split write");
    // R9: command codes
    send(16'h0300, 4, '0, 0, 1, 0, 0, 0, 0, 0, "R9 locked read");
    send(16'h0308, 8, 64'hCAFE, 1, 1, 1, 0, 0, 0, 0, "R9 locked write beats swap");
    send(16'h0310, 2, 64'hBEEF, 1, 0, 1, 0, 0, 0, 0, "R9 swap");
    send(16'h0316, 4, '0, 0, 0, 1, 0, 0, 0, 0, "R4 swap flag on read splits");
    // R4: atomic crossing
    send(16'h0406, 4, '0, 0, 1, 0, 0, 0, 0, 0, "R4 locked read crossing");
    send(16'h040E, 4, 64'h55, 1, 0, 1, 0, 0, 0, 0, "R4 swap crossing");
    // R8: faults
    send(16'h0506, 4, '0, 0, 0, 0, 0, 0, 1, 1, "R8 both halves fault");
    send(16'h0506, 4, '0, 0, 0, 0, 0, 0, 0, 1, "R8 high half fault");
    send(16'h0500, 4, '0, 0, 0, 0, 0, 0, 0, 1, "R8 high flag ignored unsplit");
    send(16'h0506, 4, '0, 0, 0, 0, 1, 0, 1, 0, "R8 prefetch fault suppressed");
    // R10: no access
    send(16'h0606, 4, '0, 0, 0, 0, 0, 1, 0, 0, "R10 no access");
    // R6: refusals
    refuse_mode = 1;
    send(16'h0706, 6, '0, 0, 0, 0, 0, 0, 0, 0, "R6 refused split read");
    send(16'h0720, 3, 64'hABCDEF, 1, 0, 0, 0, 0, 0, 0, "R6 refused write");
    refuse_mode = 0;
    // R7: nacks
    nack_mode = 1;
    send(16'h0805, 6, '0, 0, 0, 0, 0, 0, 0, 0, "R7 nacked split read");
    send(16'h0810, 8, '0, 0, 0, 0, 0, 0, 0, 0, "R7 nacked read");
    refuse_mode = 1;
    send(16'h0827, 5, 64'h0102030405, 1, 0, 0, 0, 0, 0, 0, "R7 nack and refuse");
    send(16'h0833, 7, '0, 0, 0, 0, 0, 0, 0, 0, "R7 nack and refuse read");
    refuse_mode = 0;
    nack_mode = 0;
    send(16'h0900, 1, '0, 0, 0, 0, 0, 0, 0, 0, "R5 single byte");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule